// File: doc/BRIEF.md
# Resynchronising Oversampled Baud Tick Generator

This block turns a clock running at sixteen times the serial bit rate into a single-cycle baud tick, usable as a clock enable by the receive logic in the same clock domain. Left alone, it divides by sixteen and emits one tick per bit period. It also produces a half-period strobe, which falls midway between consecutive ticks.

The attached receiver raises a clear request while it sits idle. The raw receive line idles high. It first passes through a two-flop synchroniser. When the request is high and the synchronised line is low, the start of a start bit has been seen. The divider is then preset to half a bit period instead of zero. The next tick therefore lands in the middle of the start bit, as seen through the synchroniser, and each later tick lands in the middle of the following data bit. The receiver drops the request once it leaves idle, so low data bits never disturb the phase.

Top module: `baud_tick_gen`

## Requirements
- R1: The active-low reset `rstN` is asynchronous. While it is low, `baudTick` and `halfTick` are 0. With no realignment, the first `baudTick` is visible after the 16th rising edge following release.
- R2: In free-running operation `baudTick` is a pulse one clock cycle wide, repeating every 16 clock cycles.
- R3: A realignment taken at a rising edge presets the divider to 8. `baudTick` is then visible after the 8th following edge, and every 16 cycles after that.
- R4: `rxLine` passes through two flops before use. If a low level is first sampled at edge n while `clearReq` is high, the realignment is taken at edge n+2.
- R5: `clearReq` has no effect while the synchronised line is high. A low line has no effect while `clearReq` is low. In both cases the tick phase is unchanged.
- R6: When a realignment and the terminal count fall on the same edge, the realignment wins. No tick is issued for that edge, and the divider loads 8.
- R7: While a qualified request is held over several edges, no tick or strobe is issued and the divider stays at 8. The next tick follows 8 edges after the last qualified edge.
- R8: `halfTick` is a one-cycle pulse visible after each edge at which the divider reaches 8 by counting, never at an edge that takes a realignment. It falls 8 cycles after each free-running tick and never coincides with `baudTick`.
- R9: For a ten-bit frame whose start edge first reaches the synchroniser at edge s, the ten ticks are visible after edges s+10+16·b, for b = 0..9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, sixteen times the bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| clearReq | input | 1 | Realign request from the receiver, high while it is idle |
| rxLine | input | 1 | Raw serial receive line, idles high |
| baudTick | output | 1 | One-cycle tick per bit period, at the bit centre after realignment |
| halfTick | output | 1 | One-cycle strobe midway between consecutive ticks |

## Verification
The hardest case to reach from the ports is a realignment that lands exactly on the terminal count. That edge is only known to a bench that tracks the divider phase from reset and schedules the line fall two edges ahead, to cover the synchroniser delay. The stimulus makes that coincidence, and a multi-cycle held request, directed cases at known edges. Random frames then start after random idle lengths, so the start bit meets the divider at arbitrary phases while the request is held high and the line is high. The bench predicts every tick and strobe from the last phase anchor, which is either the reset or the most recent realignment edge.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  // Strobes from the control decision to the divider datapath
  typedef struct packed {
    logic preset;    // load the half-period value
    logic wrap;      // terminal count reached, return to zero
    logic advance;   // ordinary increment
    logic fireTick;  // issue the baud tick
    logic fireHalf;  // issue the half-period strobe
  } baudCtl_t;

endpackage

// File: rtl/baud_line_sync.sv
module baud_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawLine,
  output logic syncLine
);

  logic [STAGES-1:0] stageQ;

  // Reset to the idle (high) level so no false start appears after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= '1;
    end else begin
      stageQ <= {stageQ[STAGES-2:0], rawLine};
    end
  end

  assign syncLine = stageQ[STAGES-1];

endmodule

// File: rtl/baud_tick_ctrl.sv
module baud_tick_ctrl
  import baud_tick_pkg::*;
(
  input  logic     clearReq,
  input  logic     lineSync,
  input  logic     atTerminal,
  input  logic     atHalfPrev,
  output baudCtl_t ctl
);

  logic realign;

  always_comb begin
    // Realignment needs the receiver idle and a start level on the line
    realign      = clearReq & ~lineSync;
    ctl.preset   = realign;
    ctl.wrap     = ~realign & atTerminal;
    ctl.advance  = ~realign & ~atTerminal;
    ctl.fireTick = ~realign & atTerminal;
    ctl.fireHalf = ~realign & atHalfPrev;
  end

endmodule

// File: rtl/baud_tick_dpath.sv
module baud_tick_dpath
  import baud_tick_pkg::*;
#(
  parameter int DIVISOR = 16,
  parameter bit HALF_EN = 1'b1
) (
  input  logic     clk,
  input  logic     rstN,
  input  baudCtl_t ctl,
  output logic     atTerminal,
  output logic     atHalfPrev,
  output logic     baudTick,
  output logic     halfTick
);

  localparam int CNT_W = $clog2(DIVISOR);
  localparam int HALF  = DIVISOR / 2;

  logic [CNT_W-1:0] phaseCnt;
  logic             tickQ;

  assign atTerminal = (phaseCnt == CNT_W'(DIVISOR - 1));
  assign atHalfPrev = (phaseCnt == CNT_W'(HALF - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (ctl.preset) begin
      phaseCnt <= CNT_W'(HALF);
    end else if (ctl.wrap) begin
      phaseCnt <= '0;
    end else if (ctl.advance) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickQ <= 1'b0;
    end else begin
      tickQ <= ctl.fireTick;
    end
  end

  assign baudTick = tickQ;

  generate
    if (HALF_EN) begin : g_half
      logic halfQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          halfQ <= 1'b0;
        end else begin
          halfQ <= ctl.fireHalf;
        end
      end
      assign halfTick = halfQ;
    end else begin : g_noHalf
      assign halfTick = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int DIVISOR     = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit HALF_EN     = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic clearReq,
  input  logic rxLine,
  output logic baudTick,
  output logic halfTick
);

  logic     rxSync;
  logic     atTerminal;
  logic     atHalfPrev;
  baudCtl_t ctl;

  baud_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .rawLine  (rxLine),
    .syncLine (rxSync)
  );

  baud_tick_ctrl u_ctrl (
    .clearReq   (clearReq),
    .lineSync   (rxSync),
    .atTerminal (atTerminal),
    .atHalfPrev (atHalfPrev),
    .ctl        (ctl)
  );

  baud_tick_dpath #(.DIVISOR(DIVISOR), .HALF_EN(HALF_EN)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .atTerminal (atTerminal),
    .atHalfPrev (atHalfPrev),
    .baudTick   (baudTick),
    .halfTick   (halfTick)
  );

endmodule

// File: rtl/baud_tick_checker.sv
module baud_tick_checker #(
  parameter int DIVISOR = 16
) (
  input logic clk,
  input logic rstN,
  input logic clearReq,
  input logic lineSync,
  input logic baudTick,
  input logic halfTick
);

  localparam int HALF  = DIVISOR / 2;
  localparam int GAP_W = $clog2(DIVISOR) + 2;

  logic             realign;
  logic [GAP_W-1:0] gapCnt;
  logic             fromAlign;

  assign realign = clearReq & ~lineSync;

  // Cycles since the last realignment or the last observed tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt    <= '0;
      fromAlign <= 1'b0;
    end else if (realign) begin
      gapCnt    <= '0;
      fromAlign <= 1'b1;
    end else if (baudTick) begin
      gapCnt    <= GAP_W'(1);
      fromAlign <= 1'b0;
    end else if (gapCnt <= GAP_W'(DIVISOR)) begin
      gapCnt    <= gapCnt + 1'b1;
    end
  end

  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (baudTick && !fromAlign) |-> (gapCnt == GAP_W'(DIVISOR)));

  assert_tick_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |=> !baudTick);

  assert_tick_half_R3: assert property (@(posedge clk) disable iff (!rstN)
    (baudTick && fromAlign) |-> (gapCnt == GAP_W'(HALF)));

  assert_align_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    realign |=> (!baudTick && !halfTick));

  assert_half_apart_R8: assert property (@(posedge clk) disable iff (!rstN)
    halfTick |-> !baudTick);

endmodule

bind baud_tick_gen baud_tick_checker #(.DIVISOR(DIVISOR)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clearReq (clearReq),
  .lineSync (rxSync),
  .baudTick (baudTick),
  .halfTick (halfTick)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;

  localparam int DIV  = 16;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rstN     = 1'b1;
  logic clearReq = 1'b0;
  logic rxLine   = 1'b1;
  logic baudTick;
  logic halfTick;

  int edgeNo     = 0;
  int anchorEdge = 0;
  int anchorVal  = 0;
  int nCmp       = 0;
  int nBad       = 0;
  bit finished   = 1'b0;

  baud_tick_gen i_baud_tick_gen (
    .clk      (clk),
    .rstN     (rstN),
    .clearReq (clearReq),
    .rxLine   (rxLine),
    .baudTick (baudTick),
    .halfTick (halfTick)
  );

  // Divider value after edge k, from the last anchor (reset or realignment)
  function automatic int phaseAt(int k);
    return (anchorVal + k - anchorEdge) % DIV;
  endfunction

  function automatic bit expTick(int k);
    if (k <= anchorEdge) return 1'b0;
    return phaseAt(k) == 0;
  endfunction

  function automatic bit expHalf(int k);
    if (k <= anchorEdge) return 1'b0;
    return phaseAt(k) == HALF;
  endfunction

  task automatic check(input logic act, input bit exp, input string tag,
                       input string what);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s at edge %0d: actual %b expected %b",
               tag, what, edgeNo, act, exp);
    end
  endtask

  task automatic step(input string tTag, input string hTag);
    @(posedge clk);
    edgeNo++;
    #1;
    check(baudTick, expTick(edgeNo), tTag, "baudTick");
    check(halfTick, expHalf(edgeNo), hTag, "halfTick");
  endtask

  task automatic realignNext();
    anchorEdge = edgeNo + 1;
    anchorVal  = HALF;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1 rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs low while reset is held
    check(baudTick, 1'b0, "R1", "baudTick in reset");
    check(halfTick, 1'b0, "R1", "halfTick in reset");
    rstN       = 1'b1;
    edgeNo     = 0;
    anchorEdge = 0;
    anchorVal  = 0;

    // R1: first tick after the 16th edge; R2: free-running period
    for (int i = 1; i <= 16; i++) step("R1", "R8");
    for (int i = 17; i <= 32; i++) step("R2", "R8");

    // R5: request while line high changes nothing
    clearReq = 1'b1;
    for (int i = 0; i < 8; i++) step("R5", "R8");
    clearReq = 1'b0;

    // R6: realignment on the terminal-count edge 64
    while (edgeNo < 61) step("R2", "R8");
    rxLine = 1'b0;
    step("R5", "R8");
    step("R5", "R8");
    clearReq = 1'b1;
    realignNext();
    step("R6", "R8");
    clearReq = 1'b0;
    rxLine   = 1'b1;
    for (int i = 0; i < 24; i++) step("R3", "R8");

    // R7: request held with line low over five qualified edges
    rxLine = 1'b0;
    step("R5", "R8");
    step("R5", "R8");
    clearReq = 1'b1;
    for (int h = 0; h < 5; h++) begin
      realignNext();
      step("R7", "R8");
    end
    clearReq = 1'b0;
    rxLine   = 1'b1;
    for (int i = 0; i < 20; i++) step("R7", "R8");

    // R9: random frames at arbitrary phases; R4 on the qualifying edge
    for (int f = 0; f < 30; f++) begin
      int idle;
      idle     = $urandom_range(0, 40);
      clearReq = 1'b1;
      rxLine   = 1'b1;
      for (int i = 0; i < idle; i++) step("R5", "R8");
      rxLine = 1'b0;
      for (int k = 1; k <= 160; k++) begin
        if (k > 1 && ((k - 1) % DIV) == 0) begin
          if (((k - 1) / DIV) == 9) rxLine = 1'b1;
          else rxLine = 1'($urandom_range(0, 1));
        end
        if (k == 3) realignNext();
        step((k == 3) ? "R4" : "R9", "R8");
        if (k == 3) clearReq = 1'b0;
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog R2: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule